// File: doc/BRIEF.md
# Fine-Correction Time-of-Day Counter

This block keeps a seconds and sub-seconds time-of-day value for a precision time protocol clock. It runs from a free-running system clock. The frequency is trimmed finely through a 32-bit addend. On every clock cycle the addend is added into a 32-bit accumulator. Each carry out of that addition is one time tick, and each tick moves the sub-seconds count on by a programmable increment. The sub-seconds are counted in units of 2^-31 s, so a tick of T ns needs an increment of T * 2^31 / 10^9. A 20 ns tick, for example, gives 43.

Software picks the increment from the tick length it wants. The increment does not depend on the clock frequency. Software then sets the addend so that addend * increment = 2^63 / f_clk. At 216 MHz with an increment of 43 the addend is 0x3B309D72. The tick length must be chosen so that the addend still fits in 32 bits. Drift is corrected by rewriting the addend while the clock runs. A separate command loads a new time of day from two shadow registers.

Top module: `ptp_fine_clock`

## Requirements
- R1: After reset, seconds, sub-seconds and the tick strobe are all zero. The addend and the increment are also zero.
- R2: Each rising clock edge adds the addend into the 32-bit accumulator, modulo 2^32. A carry out raises `tickPulse` for the one cycle after that edge. Starting from an accumulator of zero, N edges give floor(N * addend / 2^32) ticks.
- R3: Each tick adds the increment to `subSeconds` in the same edge. With no tick and no initialize command, seconds and sub-seconds hold their values.
- R4: When sub-seconds plus the increment reaches or exceeds 2^31, sub-seconds become that sum minus 2^31. `seconds` rises by one at the same edge.
- R5: Writing the addend does not reset the accumulator. The new value is first added at the edge after the write edge.
- R6: An initialize command loads seconds and sub-seconds from the shadow registers and clears the accumulator. It also suppresses any tick that falls at the same edge.
- R7: An increment of zero freezes seconds and sub-seconds. The accumulator keeps running and `tickPulse` still fires.
- R8: Writes happen when `wrEn` is high at a clock edge. Address 0 writes the addend (bits 31:0). Address 1 writes the increment (bits 7:0). Address 2 writes the seconds shadow. Address 3 writes the sub-seconds shadow (bits 30:0). Address 4 issues the initialize command, whatever the data. Other addresses do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 32 | Register write data |
| seconds | output | 32 | Current seconds |
| subSeconds | output | 31 | Current sub-seconds in 2^-31 s units |
| tickPulse | output | 1 | One-cycle strobe for each accumulator carry |

## Verification
The assertions assume the write interface carries one address per cycle, so an initialize command never coincides with a shadow write. They also assume any increment software uses is below 2^31, which holds because the field is 8 bits wide. Each scenario writes the shadows, the addend and the increment in separate cycles before issuing the initialize command. Every run then starts from a cleared accumulator, which makes the tick counts exact.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  localparam int ACC_W  = 32;
  localparam int INC_W  = 8;
  localparam int SEC_W  = 32;
  localparam int SUB_W  = 31;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] ADR_ADDEND = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_INCR   = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_SECSH  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_SUBSH  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_INIT   = 3'd4;

  typedef struct packed {
    logic ldAddend;
    logic ldIncr;
    logic ldSecShadow;
    logic ldSubShadow;
    logic initTime;
  } todStrobe_t;
endpackage

// File: rtl/ptp_tod_ctrl.sv
module ptp_tod_ctrl
  import ptp_tod_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output todStrobe_t        strobe
);
  always_comb begin
    strobe             = '0;
    strobe.ldAddend    = wrEn && (wrAddr == ADR_ADDEND);
    strobe.ldIncr      = wrEn && (wrAddr == ADR_INCR);
    strobe.ldSecShadow = wrEn && (wrAddr == ADR_SECSH);
    strobe.ldSubShadow = wrEn && (wrAddr == ADR_SUBSH);
    strobe.initTime    = wrEn && (wrAddr == ADR_INIT);
  end
endmodule

// File: rtl/ptp_tod_datapath.sv
module ptp_tod_datapath
  import ptp_tod_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  todStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [SEC_W-1:0]  secOut,
  output logic [SUB_W-1:0]  subOut,
  output logic              tickOut
);
  logic [ACC_W-1:0] addendReg;
  logic [ACC_W-1:0] accReg;
  logic [INC_W-1:0] incReg;
  logic [SEC_W-1:0] secShadow;
  logic [SUB_W-1:0] subShadow;
  logic [SEC_W-1:0] secReg;
  logic [SUB_W-1:0] subReg;
  logic             tickReg;

  logic [ACC_W:0]   accSum;
  logic             carry;
  logic [SUB_W:0]   subSum;
  logic             wrapNeeded;

  assign accSum     = {1'b0, accReg} + {1'b0, addendReg};
  assign carry      = accSum[ACC_W];
  assign subSum     = {1'b0, subReg} + (SUB_W+1)'(incReg);
  assign wrapNeeded = subSum[SUB_W];

  // Software-visible configuration
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addendReg <= '0;
      incReg    <= '0;
      secShadow <= '0;
      subShadow <= '0;
    end else begin
      if (strobe.ldAddend)    addendReg <= wrData[ACC_W-1:0];
      if (strobe.ldIncr)      incReg    <= wrData[INC_W-1:0];
      if (strobe.ldSecShadow) secShadow <= wrData[SEC_W-1:0];
      if (strobe.ldSubShadow) subShadow <= wrData[SUB_W-1:0];
    end
  end

  // Accumulator and time of day
  always_ff @(posedge clk) begin
    if (!rstN) begin
      accReg  <= '0;
      secReg  <= '0;
      subReg  <= '0;
      tickReg <= 1'b0;
    end else if (strobe.initTime) begin
      accReg  <= '0;
      secReg  <= secShadow;
      subReg  <= subShadow;
      tickReg <= 1'b0;
    end else begin
      accReg  <= accSum[ACC_W-1:0];
      tickReg <= carry;
      if (carry) begin
        subReg <= subSum[SUB_W-1:0];
        if (wrapNeeded) secReg <= secReg + SEC_W'(1);
      end
    end
  end

  assign secOut  = secReg;
  assign subOut  = subReg;
  assign tickOut = tickReg;

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (!carry && !strobe.initTime) |=> ($stable(secReg) && $stable(subReg) && !tickReg)); // R3

  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.initTime) |=> (secReg == $past(secReg) || (tickReg && secReg == $past(secReg) + SEC_W'(1)))); // R4

  AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.initTime |=> (accReg == '0 && !tickReg && secReg == $past(secShadow) && subReg == $past(subShadow))); // R6

  AST_ZERO_INC: assert property (@(posedge clk) disable iff (!rstN)
    (incReg == '0 && !strobe.initTime) |=> ($stable(secReg) && $stable(subReg))); // R7

  AST_ADDEND_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ldAddend && !strobe.initTime && !carry) |=> (accReg != '0 || $past(accReg) == '0 || $past(accSum[ACC_W-1:0]) == '0)); // R5
endmodule

// File: rtl/ptp_fine_clock.sv
module ptp_fine_clock
  import ptp_tod_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [2:0]  wrAddr,
  input  logic [31:0] wrData,
  output logic [31:0] seconds,
  output logic [30:0] subSeconds,
  output logic        tickPulse
);
  todStrobe_t strobe;

  ptp_tod_ctrl i_ctrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .strobe (strobe)
  );

  ptp_tod_datapath i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (wrData),
    .secOut  (seconds),
    .subOut  (subSeconds),
    .tickOut (tickPulse)
  );
endmodule

// File: tb/test_ptp_fine_clock.sv
module test_ptp_fine_clock;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] seconds;
  logic [30:0] subSeconds;
  logic        tickPulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  ptp_fine_clock i_ptp_fine_clock (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .seconds(seconds), .subSeconds(subSeconds), .tickPulse(tickPulse)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a negedge; the write lands on the following posedge.
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrAddr = '0; wrData = '0;
  endtask

  task automatic runCount(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tickPulse) cnt++;
    end
  endtask

  task automatic setup(input logic [31:0] addend, input logic [7:0] inc,
                       input logic [31:0] sec0, input logic [30:0] sub0);
    wr(3'd0, addend);
    wr(3'd1, {24'd0, inc});
    wr(3'd2, sec0);
    wr(3'd3, {1'b0, sub0});
    wr(3'd4, 32'hDEAD_BEEF);
  endtask

  task automatic testReset();
    check("R1 seconds", seconds, 0);
    check("R1 subSeconds", subSeconds, 0);
    check("R1 tickPulse", tickPulse, 0);
  endtask

  task automatic testInitLoad();
    setup(32'd0, 8'd43, 32'd100, 31'd5);
    check("R8 R6 seconds loaded", seconds, 100);
    check("R8 R6 subSeconds loaded", subSeconds, 5);
  endtask

  task automatic testHalfRate();
    int cnt;
    setup(32'h8000_0000, 8'd43, 32'd10, 31'd5);
    runCount(200, cnt);
    check("R2 ticks at half rate", cnt, 100);
    check("R3 subSeconds after 100 ticks", subSeconds, 5 + 100 * 43);
    check("R3 seconds unchanged", seconds, 10);
  endtask

  task automatic testNominal();
    int cnt;
    longint n = 20000;
    longint a = 64'h3B30_9D72;
    longint expTicks;
    setup(32'h3B30_9D72, 8'd43, 32'd0, 31'd0);
    runCount(int'(n), cnt);
    expTicks = (n * a) >> 32;
    check("R2 nominal 216MHz tick count", cnt, expTicks);
    check("R3 nominal subSeconds", subSeconds, expTicks * 43);
  endtask

  task automatic testWrap();
    int cnt;
    setup(32'h8000_0000, 8'd43, 32'd7, 31'h7FFF_FFCE);
    runCount(4, cnt);
    check("R4 wrap tick count", cnt, 2);
    check("R4 seconds after wrap", seconds, 8);
    check("R4 subSeconds after wrap", subSeconds, 36);
    setup(32'h8000_0000, 8'd43, 32'hFFFF_FFFF, 31'h7FFF_FFD5);
    runCount(2, cnt);
    check("R4 exact boundary subSeconds", subSeconds, 0);
    check("R4 exact boundary seconds rollover", seconds, 0);
  endtask

  task automatic testAddendPhase();
    int cnt;
    setup(32'h8000_0000, 8'd1, 32'd0, 31'd0);
    wr(3'd0, 32'h4000_0000);
    runCount(7, cnt);
    check("R5 phase kept across addend write", cnt, 2);
  endtask

  task automatic testInitPriority();
    int cnt;
    setup(32'h8000_0000, 8'd43, 32'd1, 31'd1);
    wr(3'd2, 32'd50);
    wr(3'd3, 32'd10);
    wr(3'd4, 32'd0);
    check("R6 init wins seconds", seconds, 50);
    check("R6 init wins subSeconds", subSeconds, 10);
    check("R6 no tick at init edge", tickPulse, 0);
    runCount(2, cnt);
    check("R6 accumulator cleared", cnt, 1);
  endtask

  task automatic testZeroInc();
    int cnt;
    setup(32'h8000_0000, 8'd0, 32'd3, 31'd9);
    runCount(10, cnt);
    check("R7 ticks continue", cnt, 5);
    check("R7 seconds frozen", seconds, 3);
    check("R7 subSeconds frozen", subSeconds, 9);
  endtask

  task automatic testBadAddr();
    int cnt;
    setup(32'h8000_0000, 8'd0, 32'd21, 31'd22);
    wr(3'd7, 32'hFFFF_FFFF);
    wr(3'd5, 32'hFFFF_FFFF);
    runCount(4, cnt);
    check("R8 unused address no tick change", cnt, 2);
    check("R8 unused address seconds", seconds, 21);
    check("R8 unused address subSeconds", subSeconds, 22);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testInitLoad();
    testHalfRate();
    testNominal();
    testWrap();
    testAddendPhase();
    testInitPriority();
    testZeroInc();
    testBadAddr();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule